// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block is a small pool of reservation stations that sits in front of one execution unit of an out-of-order floating-point core. An instruction is accepted into any free station. For each of its two sources it brings either a value that is already known or the tag of the station that will produce it. A tag of zero means "value present", so no separate ready bit is kept. Each station carries its own fixed, non-zero tag, and a newly accepted instruction learns that tag at issue.

While a station waits, it snoops a shared result broadcast bus that carries a data word and the tag of the producing station. Every pending source whose tag matches latches the data and clears its tag. A source whose producer broadcasts in the very cycle of issue is captured directly, so the new station never waits on a tag that has already gone by. Once both tags of a station are zero it competes for dispatch. The lowest-index ready station is handed to the execution unit, one per cycle, and only while the unit accepts. The station stays occupied until the bus carries its own tag, which is the write-back of its result. It then becomes free again.

Each station is a three-state machine. FREE goes to HELD on **alloc** (issue accepted into this station). HELD goes to EXEC on **grant** (dispatched to the unit). EXEC goes to FREE on **retire** (the bus carries the station's own tag). Being ready is not a state: it is derived in HELD from both tags being zero.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is FREE: `iss_ready` is 1, `iss_tag` is 1 and `disp_valid` is 0.
- R2: An accepted issue goes into the lowest-index FREE station. Station i has tag TAG_BASE+i (1..4 by default), and `iss_tag` shows the tag that the next issue will receive.
- R3: With no FREE station, `iss_ready` is 0, and an issue attempted then changes no station and never reaches dispatch.
- R4: A source whose tag is 0 is taken as a present value. An instruction issued with both tags 0 is offered on `disp_valid` in the cycle after issue.
- R5: A HELD station whose source tag equals a valid broadcast tag latches `bus_data` into that source and clears the tag. Both sources can capture from one broadcast.
- R6: A source tag that matches a broadcast in the same cycle as its issue is captured at issue.
- R7: A broadcast whose tag matches no pending source changes no operand.
- R8: When several stations are ready, the lowest-index one is presented on `disp_op`, `disp_a`, `disp_b` and `disp_tag`, and at most one station is dispatched per cycle.
- R9: A dispatched station becomes FREE after the cycle in which the bus carries its own tag.
- R10: While `disp_ready` is 0, no station is dispatched and the offered station stays offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_vj | input | DATA_W | First source value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First source producer tag, 0 = value present |
| iss_vk | input | DATA_W | Second source value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second source producer tag, 0 = value present |
| iss_ready | output | 1 | A FREE station exists |
| iss_tag | output | TAG_W | Tag that the next accepted issue receives |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of the producing station |
| bus_data | input | DATA_W | Broadcast result |
| disp_ready | input | 1 | Execution unit accepts an operation |
| disp_valid | output | 1 | A ready station is offered |
| disp_op | output | OP_W | Operation of the offered station |
| disp_a | output | DATA_W | First operand |
| disp_b | output | DATA_W | Second operand |
| disp_tag | output | TAG_W | Tag of the offered station |

## Verification
A scripted sequence fills the pool with a mix of instructions. Some have both values present, some wait on a station of the pool, and some wait on an outside producer, including one whose producer broadcasts in the issue cycle. The dispatch order then shows whether capture, same-cycle capture and lowest-index selection act on the right stations. A broadcast with a foreign tag and an issue into a full pool follow. Each would change which station is offered next if it leaked into an operand or a station. Directed tests cover reset and a single broadcast that completes both sources of one station at once.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        RS_FREE = 2'd0,
        RS_HELD = 2'd1,
        RS_EXEC = 2'd2
    } rs_state_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   a_op,
    input  logic [DATA_W-1:0] a_vj,
    input  logic [TAG_W-1:0]  a_qj,
    input  logic [DATA_W-1:0] a_vk,
    input  logic [TAG_W-1:0]  a_qk,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);
    localparam logic [TAG_W-1:0] OWN = TAG_W'(MY_TAG);

    rs_state_e        st, st_nxt;
    logic [TAG_W-1:0] qj, qk;
    logic             retire;

    function automatic logic snoop_hit(input logic [TAG_W-1:0] t);
        return bus_valid && (t != '0) && (t == bus_tag);
    endfunction

    assign retire = bus_valid && (bus_tag == OWN);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RS_FREE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RS_FREE: if (alloc)  st_nxt = RS_HELD;
            RS_HELD: if (grant)  st_nxt = RS_EXEC;
            RS_EXEC: if (retire) st_nxt = RS_FREE;
            default:             st_nxt = RS_FREE;
        endcase
    end

    always_comb begin
        busy  = (st != RS_FREE);
        ready = (st == RS_HELD) && (qj == '0) && (qk == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op <= '0; vj <= '0; vk <= '0; qj <= '0; qk <= '0;
        end else if (alloc) begin
            op <= a_op;
            if (snoop_hit(a_qj)) begin vj <= bus_data; qj <= '0; end
            else                 begin vj <= a_vj;     qj <= a_qj; end
            if (snoop_hit(a_qk)) begin vk <= bus_data; qk <= '0; end
            else                 begin vk <= a_vk;     qk <= a_qk; end
        end else if (st == RS_HELD) begin
            if (snoop_hit(qj)) begin vj <= bus_data; qj <= '0; end
            if (snoop_hit(qk)) begin vk <= bus_data; qk <= '0; end
        end
    end

    // R3
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy);
    // R8
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ready);
    // R5
    capture_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RS_HELD && !alloc && bus_valid && qj != '0 && bus_tag == qj)
        |=> (qj == '0 && vj == $past(bus_data)));
    // R9
    retire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RS_EXEC && retire) |=> !busy);
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 4,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int OP_W     = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              disp_ready,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    logic [NUM_RS-1:0] busy, rdy, free_gnt, rdy_gnt, alloc, grant;
    logic [IDX_W-1:0]  free_idx, rdy_idx;
    logic              free_any, rdy_any;
    logic [OP_W-1:0]   e_op [NUM_RS];
    logic [DATA_W-1:0] e_vj [NUM_RS];
    logic [DATA_W-1:0] e_vk [NUM_RS];

    rs_pick #(.N(NUM_RS)) u_free_pick (
        .req(~busy), .gnt(free_gnt), .idx(free_idx), .any(free_any));
    rs_pick #(.N(NUM_RS)) u_rdy_pick (
        .req(rdy), .gnt(rdy_gnt), .idx(rdy_idx), .any(rdy_any));

    assign alloc = free_gnt & {NUM_RS{iss_valid}};
    assign grant = rdy_gnt & {NUM_RS{disp_ready}};

    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
        rs_entry #(
            .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
            .MY_TAG(TAG_BASE + g)
        ) u_ent (
            .clk(clk), .rst_n(rst_n), .alloc(alloc[g]),
            .a_op(iss_op), .a_vj(iss_vj), .a_qj(iss_qj),
            .a_vk(iss_vk), .a_qk(iss_qk),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
            .grant(grant[g]), .busy(busy[g]), .ready(rdy[g]),
            .op(e_op[g]), .vj(e_vj[g]), .vk(e_vk[g]));
    end

    always_comb begin
        iss_ready  = free_any;
        iss_tag    = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
        disp_valid = rdy_any;
        disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(rdy_idx);
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (rdy_gnt[i]) begin
                disp_op = e_op[i];
                disp_a  = e_vj[i];
                disp_b  = e_vk[i];
            end
        end
    end

    // R8
    one_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R3
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> (alloc == '0));
    // R10
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> disp_valid);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (busy == '0));
endmodule

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;

    typedef struct packed {
        logic        iv;  logic [3:0] op;
        logic [15:0] vj;  logic [3:0] qj;
        logic [15:0] vk;  logic [3:0] qk;
        logic        bv;  logic [3:0] bt; logic [15:0] bd;
        logic        dr;  logic [3:0] rq;
        logic        eir; logic [3:0] eit;
        logic        edv; logic [3:0] eop;
        logic [15:0] ea;  logic [15:0] eb;
    } step_t;

    // Stations have tags 1..4; tag 0 means value present.
    localparam step_t STEPS [13] = '{
        // R2: op1 with both values into station 1
        '{1,1,10,0,20,0, 0,0,0, 0,2, 1,1, 0,0,0,0},
        // R4: op1 offered the cycle after issue; op2 waits on tag 1
        '{1,2,0,1,5,0, 0,0,0, 0,4, 1,2, 1,1,10,20},
        // R10: op1 still offered; R6: op3 source tag 7 broadcast this cycle
        '{1,3,0,7,6,0, 1,7,77, 1,10, 1,3, 1,1,10,20},
        // R6: op3 ready with 77
        '{0,0,0,0,0,0, 0,0,0, 1,6, 1,4, 1,3,77,6},
        // R9/R5: tag 1 result frees station 1 and feeds op2
        '{0,0,0,0,0,0, 1,1,100, 1,8, 1,4, 0,0,0,0},
        // R5: op2 has 100; op4 waits on 9 into station 1
        '{1,4,0,9,1,0, 0,0,0, 0,5, 1,1, 1,2,100,5},
        // R7: foreign tag 8 broadcast; op5 waits on tag 3
        '{1,5,2,0,0,3, 1,8,88, 0,10, 1,4, 1,2,100,5},
        // R7: op4 did not take 88; R3: op6 refused, pool full
        '{1,6,3,0,3,0, 0,0,0, 0,7, 0,0, 1,2,100,5},
        // R3: still op2 offered; tag 3 result frees station 3
        '{0,0,0,0,0,0, 1,3,33, 1,3, 0,0, 1,2,100,5},
        // R9: station 3 free again; op5 has 33; tag 9 arrives
        '{0,0,0,0,0,0, 1,9,99, 0,9, 1,3, 1,5,2,33},
        // R8: op4 (station 1) wins over op5 (station 4)
        '{0,0,0,0,0,0, 0,0,0, 1,8, 1,3, 1,4,99,1},
        // R8: op5 next
        '{0,0,0,0,0,0, 0,0,0, 1,8, 1,3, 1,5,2,33},
        // R8: nothing left, refused op6 never appears
        '{0,0,0,0,0,0, 0,0,0, 0,8, 1,3, 0,0,0,0}
    };

    logic          clk = 0, rst_n = 0;
    logic          iss_valid = 0, bus_valid = 0, disp_ready = 0;
    logic [3:0]    iss_op = 0, iss_qj = 0, iss_qk = 0, bus_tag = 0;
    logic [DW-1:0] iss_vj = 0, iss_vk = 0, bus_data = 0;
    logic          iss_ready, disp_valid;
    logic [3:0]    iss_tag, disp_op, disp_tag;
    logic [DW-1:0] disp_a, disp_b;
    int            checks = 0, errors = 0;
    bit            done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_pool dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_ready(iss_ready), .iss_tag(iss_tag), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_data(bus_data), .disp_ready(disp_ready),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_tag(disp_tag));

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input step_t s);
        iss_valid = s.iv; iss_op = s.op;
        iss_vj = DW'(s.vj); iss_qj = s.qj; iss_vk = DW'(s.vk); iss_qk = s.qk;
        bus_valid = s.bv; bus_tag = s.bt; bus_data = DW'(s.bd);
        disp_ready = s.dr;
    endtask

    task automatic quiet();
        drive('0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R1
        chk("R1", "iss_ready", DW'(iss_ready), 1);
        chk("R1", "iss_tag", DW'(iss_tag), 1);
        chk("R1", "disp_valid", DW'(disp_valid), 0);

        for (int i = 0; i < 13; i++) begin
            string rq;
            if (i != 0) @(negedge clk);
            drive(STEPS[i]);
            #1;
            rq = $sformatf("R%0d", STEPS[i].rq);
            chk("R3", $sformatf("step %0d iss_ready", i), DW'(iss_ready), DW'(STEPS[i].eir));
            if (STEPS[i].eir)
                chk("R2", $sformatf("step %0d iss_tag", i), DW'(iss_tag), DW'(STEPS[i].eit));
            chk(rq, $sformatf("step %0d disp_valid", i), DW'(disp_valid), DW'(STEPS[i].edv));
            if (STEPS[i].edv) begin
                chk(rq, $sformatf("step %0d disp_op", i), DW'(disp_op), DW'(STEPS[i].eop));
                chk(rq, $sformatf("step %0d disp_a", i), disp_a, DW'(STEPS[i].ea));
                chk(rq, $sformatf("step %0d disp_b", i), disp_b, DW'(STEPS[i].eb));
            end
        end

        // R1: reset mid-run clears busy stations
        @(negedge clk); quiet(); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        chk("R1", "iss_tag after reset", DW'(iss_tag), 1);
        chk("R1", "disp_valid after reset", DW'(disp_valid), 0);

        // R5: both sources wait on tag 4, one broadcast completes both
        @(negedge clk);
        iss_valid = 1; iss_op = 7; iss_qj = 4; iss_qk = 4; iss_vj = 0; iss_vk = 0;
        @(negedge clk); quiet(); #1;
        chk("R5", "waiting on both", DW'(disp_valid), 0);
        chk("R2", "next tag", DW'(iss_tag), 2);
        bus_valid = 1; bus_tag = 4; bus_data = 64'h44;
        @(negedge clk); quiet(); #1;
        chk("R5", "double capture valid", DW'(disp_valid), 1);
        chk("R5", "double capture a", disp_a, 64'h44);
        chk("R5", "double capture b", disp_b, 64'h44);
        chk("R8", "disp_tag", DW'(disp_tag), 1);
        // R10: offer held while unit is busy
        @(negedge clk); #1;
        chk("R10", "offer held", DW'(disp_op), 7);

        done = 1;
        finish_run();
    end
endmodule